// File: doc/BRIEF.md
# Pointer-Gated Threshold VOQ Arbiter

This block is the scheduler that sits at one input of a two-stage load-balanced switch. It keeps, for each of `NQ` virtual output queues, a cell count and a rotation pointer that names the middle port due to receive that queue's next cell. Every slot the surrounding logic gives it the middle port connected in that slot and, optionally, one arriving cell tagged with its destination queue. The block answers in the same slot with at most one grant naming the queue whose head cell crosses the first fabric stage.

A queue can compete only when its rotation pointer matches the connected port, so each flow spreads its cells over the middle ports in strict rotation. Among the queues that may compete, the arbiter prefers the queue it served last and any queue whose count has reached a threshold. The threshold is either the fixed value `NQ` or the input's average queue length (total count divided by `NQ`), chosen by a mode input. Cell storage, the fabric and the middle-stage queues live elsewhere; the block only decides and keeps its counters.

Top module: `pgt_voq_sched`

## Requirements
- R1: After reset every queue count and the total are zero, every rotation pointer is 0, the last-served queue is 0, and `grant_vld` is low.
- R2: A queue is eligible in a slot only when its pointer equals `conn_port` and its count is non-zero; a grant only ever names an eligible queue.
- R3: When queue k is granted while `conn_port` is j, its pointer becomes (j + 1) mod `NQ` at the next clock edge, so it cannot be granted again until the connected port advances to that value.
- R4: If the last-served queue is eligible and its count is at least the threshold, it is granted.
- R5: Otherwise, if any eligible queue has a count at least the threshold, the first such queue found by scanning upward (with wrap) starting at the last-served queue index is granted.
- R6: Otherwise, if the last-served queue is eligible (non-empty, below threshold), it is granted again.
- R7: Otherwise the first eligible queue found by the same upward scan from the last-served index is granted.
- R8: With `mode_dyn` = 0 the threshold is `NQ`; with `mode_dyn` = 1 it is the total count shifted right by log2(`NQ`). Comparison is greater-or-equal.
- R9: An accepted arrival raises its queue's count at the clock edge ending the slot, so it cannot be granted within its own slot; an arrival and a grant to the same queue in one slot leave that count unchanged.
- R10: No grant is issued when no queue is eligible; `grant_vld` is then low.
- R11: The total count never exceeds `NQ`*`NQ`; an arrival in a slot where the total equals `NQ`*`NQ` and no grant is issued is discarded.
- R12: The grant is a combinational function of the slot's `conn_port` and the state held at the start of the slot; the last-served index updates only on a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dyn | input | 1 | 0: fixed threshold `NQ`; 1: threshold is the average queue length |
| arr_vld | input | 1 | A cell arrives this slot |
| arr_dst | input | log2(NQ) | Destination queue of the arriving cell |
| conn_port | input | log2(NQ) | Middle port connected in this slot |
| grant_vld | output | 1 | A queue is granted this slot |
| grant_q | output | log2(NQ) | Index of the granted queue (valid with `grant_vld`) |

## Verification
The grant is due in the same slot as the `conn_port` value it answers, with zero register stages, while counts, pointers and the last-served index take effect at the edge that closes the slot and only influence the next slot's grant. The bench therefore drives every input just after a falling edge, compares the grant a quarter period later, before the rising edge, and only then advances its own model of counts, pointers and last-served queue. Arrival visibility (R9), pointer advance (R3) and the discard at full occupancy (R11) are checked in the slot after their stimulus, and the cap is confirmed again by counting the grants needed to drain the input.

// File: rtl/pgt_pkg.sv
package pgt_pkg;

  // Which rule produced the grant of the current slot.
  typedef enum logic [2:0] {
    SRC_IDLE   = 3'd0,
    SRC_STICKY = 3'd1,
    SRC_HOT    = 3'd2,
    SRC_KEEP   = 3'd3,
    SRC_ANY    = 3'd4
  } grant_src_e;

endpackage

// File: rtl/pgt_qstate.sv
// Occupancy counter and rotation pointer of one virtual output queue.
module pgt_qstate #(
  parameter int NQ = 4,
  parameter int IW = 2,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic [IW-1:0] conn_i,
  output logic [CW-1:0] cnt_o,
  output logic [IW-1:0] ptr_o
);

  logic [CW-1:0] cnt_d;
  logic [IW-1:0] ptr_d;
  logic          upd;

  assign upd = inc_i | dec_i;

  always_comb begin
    cnt_d = cnt_o;
    if (inc_i && !dec_i) begin
      cnt_d = cnt_o + CW'(1);
    end else if (dec_i && !inc_i) begin
      cnt_d = cnt_o - CW'(1);
    end
  end

  // Power-of-two NQ: the IW-bit add wraps modulo NQ.
  always_comb begin
    ptr_d = ptr_o;
    if (dec_i) begin
      ptr_d = conn_i + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      ptr_o <= '0;
    end else if (upd) begin
      cnt_o <= cnt_d;
      ptr_o <= ptr_d;
    end
  end

endmodule

// File: rtl/pgt_rr_pick.sv
// Rotating priority scan: first set request at or above start, with wrap.
module pgt_rr_pick #(
  parameter int NQ = 4,
  parameter int IW = 2
) (
  input  logic [NQ-1:0] req_i,
  input  logic [IW-1:0] start_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  logic [IW-1:0] cand;

  always_comb begin
    found_o = 1'b0;
    idx_o   = start_i;
    cand    = start_i;
    for (int o = 0; o < NQ; o++) begin
      cand = start_i + IW'(o);
      if (!found_o && req_i[cand]) begin
        found_o = 1'b1;
        idx_o   = cand;
      end
    end
  end

endmodule

// File: rtl/pgt_thresh.sv
// Congestion threshold: fixed NQ, or total count divided by NQ.
module pgt_thresh #(
  parameter int NQ = 4,
  parameter int IW = 2,
  parameter int CW = 5
) (
  input  logic          mode_dyn_i,
  input  logic [CW-1:0] total_i,
  output logic [CW-1:0] th_o
);

  localparam logic [CW-1:0] FIXED_TH = CW'(NQ);

  always_comb begin
    if (mode_dyn_i) begin
      th_o = total_i >> IW;
    end else begin
      th_o = FIXED_TH;
    end
  end

endmodule

// File: rtl/pgt_voq_sched.sv
module pgt_voq_sched #(
  parameter int NQ = 4,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int CAP = NQ * NQ,
  localparam int CW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_dyn,
  input  logic          arr_vld,
  input  logic [IW-1:0] arr_dst,
  input  logic [IW-1:0] conn_port,
  output logic          grant_vld,
  output logic [IW-1:0] grant_q
);

  import pgt_pkg::*;

  logic [NQ-1:0][CW-1:0] cnt_q;
  logic [NQ-1:0][IW-1:0] ptr_q;
  logic [NQ-1:0]         elig;
  logic [NQ-1:0]         hot;
  logic [NQ-1:0]         inc;
  logic [NQ-1:0]         dec;
  logic [CW-1:0]         th;
  logic [CW-1:0]         tot_q;
  logic [CW-1:0]         tot_d;
  logic [IW-1:0]         last_q;
  logic [IW-1:0]         last_d;
  logic                  acc;
  logic                  hot_found;
  logic [IW-1:0]         hot_idx;
  logic                  any_found;
  logic [IW-1:0]         any_idx;
  grant_src_e            src;

  // Per-queue state
  for (genvar k = 0; k < NQ; k++) begin : g_q
    assign inc[k]  = acc && (arr_dst == IW'(k));
    assign dec[k]  = grant_vld && (grant_q == IW'(k));
    assign elig[k] = (ptr_q[k] == conn_port) && (cnt_q[k] != '0);
    assign hot[k]  = elig[k] && (cnt_q[k] >= th);

    pgt_qstate #(.NQ(NQ), .IW(IW), .CW(CW)) u_qs (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (inc[k]),
      .dec_i  (dec[k]),
      .conn_i (conn_port),
      .cnt_o  (cnt_q[k]),
      .ptr_o  (ptr_q[k])
    );
  end

  pgt_thresh #(.NQ(NQ), .IW(IW), .CW(CW)) u_th (
    .mode_dyn_i (mode_dyn),
    .total_i    (tot_q),
    .th_o       (th)
  );

  pgt_rr_pick #(.NQ(NQ), .IW(IW)) u_pick_hot (
    .req_i   (hot),
    .start_i (last_q),
    .found_o (hot_found),
    .idx_o   (hot_idx)
  );

  pgt_rr_pick #(.NQ(NQ), .IW(IW)) u_pick_any (
    .req_i   (elig),
    .start_i (last_q),
    .found_o (any_found),
    .idx_o   (any_idx)
  );

  // Rule ladder of the arbiter
  always_comb begin
    if (hot[last_q]) begin
      src = SRC_STICKY;
    end else if (hot_found) begin
      src = SRC_HOT;
    end else if (elig[last_q]) begin
      src = SRC_KEEP;
    end else if (any_found) begin
      src = SRC_ANY;
    end else begin
      src = SRC_IDLE;
    end
  end

  always_comb begin
    grant_vld = 1'b1;
    grant_q   = last_q;
    unique case (src)
      SRC_STICKY: grant_q = last_q;
      SRC_HOT:    grant_q = hot_idx;
      SRC_KEEP:   grant_q = last_q;
      SRC_ANY:    grant_q = any_idx;
      default: begin
        grant_vld = 1'b0;
        grant_q   = last_q;
      end
    endcase
  end

  // Admission and total occupancy
  assign acc = arr_vld && ((tot_q != CW'(CAP)) || grant_vld);

  always_comb begin
    tot_d = tot_q;
    if (acc && !grant_vld) begin
      tot_d = tot_q + CW'(1);
    end else if (grant_vld && !acc) begin
      tot_d = tot_q - CW'(1);
    end
  end

  assign last_d = grant_vld ? grant_q : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q <= '0;
    end else if (acc ^ grant_vld) begin
      tot_q <= tot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (grant_vld) begin
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/pgt_voq_sched_chk.sv
module pgt_voq_sched_chk #(
  parameter int NQ = 4,
  parameter int IW = 2,
  parameter int CW = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [IW-1:0]         conn_port,
  input logic [IW-1:0]         arr_dst,
  input logic                  grant_vld,
  input logic [IW-1:0]         grant_q,
  input logic                  acc,
  input logic [NQ-1:0]         elig,
  input logic [NQ-1:0][CW-1:0] cnt_q,
  input logic [NQ-1:0][IW-1:0] ptr_q,
  input logic [CW-1:0]         tot_q
);

  localparam logic [CW-1:0] CAPV = CW'(NQ * NQ);

  assert_ptr_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> (ptr_q[grant_q] == conn_port));

  assert_grant_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> (cnt_q[grant_q] != '0));

  assert_idle_when_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> !grant_vld);

  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |=> (ptr_q[$past(grant_q)] == ($past(conn_port) + IW'(1))));

  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && grant_vld && (arr_dst == grant_q))
      |=> (cnt_q[$past(grant_q)] == $past(cnt_q[grant_q])));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tot_q <= CAPV);

endmodule

bind pgt_voq_sched pgt_voq_sched_chk #(.NQ(NQ), .IW(IW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conn_port (conn_port),
  .arr_dst   (arr_dst),
  .grant_vld (grant_vld),
  .grant_q   (grant_q),
  .acc       (acc),
  .elig      (elig),
  .cnt_q     (cnt_q),
  .ptr_q     (ptr_q),
  .tot_q     (tot_q)
);

// File: tb/sim_pgt_voq_sched.sv
`timescale 1ns/1ps
module sim_pgt_voq_sched;

  localparam int NQ  = 4;
  localparam int IW  = 2;
  localparam int LG  = 2;
  localparam int CAP = NQ * NQ;

  logic          clk;
  logic          rst_n;
  logic          mode_dyn;
  logic          arr_vld;
  logic [IW-1:0] arr_dst;
  logic [IW-1:0] conn_port;
  logic          grant_vld;
  logic [IW-1:0] grant_q;

  int n_chk;
  int n_bad;

  // Reference state built from the requirements
  int mc [NQ];
  int mp [NQ];
  int mlast;
  int mtot;

  pgt_voq_sched #(.NQ(NQ)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_dyn  (mode_dyn),
    .arr_vld   (arr_vld),
    .arr_dst   (arr_dst),
    .conn_port (conn_port),
    .grant_vld (grant_vld),
    .grant_q   (grant_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Stimulus vectors {mode, arr_vld, dst[1:0], conn[1:0]}
  localparam logic [5:0] VEC [24] = '{
    6'b0_1_00_11, 6'b0_1_00_11, 6'b0_1_01_11, 6'b0_1_10_00,
    6'b0_1_00_01, 6'b0_0_00_10, 6'b0_1_11_11, 6'b0_1_11_00,
    6'b0_1_10_01, 6'b0_1_10_10, 6'b0_0_00_11, 6'b0_1_01_00,
    6'b1_1_01_01, 6'b1_1_01_10, 6'b1_1_11_11, 6'b1_0_00_00,
    6'b1_1_00_01, 6'b1_1_00_10, 6'b1_1_10_11, 6'b1_1_10_00,
    6'b0_0_00_01, 6'b0_0_00_10, 6'b0_0_00_11, 6'b0_0_00_00
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rr_scan(input logic [NQ-1:0] req, input int s);
    for (int o = 0; o < NQ; o++) begin
      if (req[(s + o) % NQ]) return (s + o) % NQ;
    end
    return -1;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NQ; k++) begin
      mc[k] = 0;
      mp[k] = 0;
    end
    mlast = 0;
    mtot  = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mode_dyn = 1'b0;
    arr_vld = 1'b0;
    arr_dst = '0;
    conn_port = '0;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk(grant_vld == 1'b0, "R1 reset grant", int'(grant_vld), 0);
  endtask

  // One slot: drive, check the grant before the edge, advance the model.
  task automatic slot(input bit md, input bit av, input int dst, input int cn);
    int th;
    int eg;
    bit ev;
    string tag;
    logic [NQ-1:0] el;
    logic [NQ-1:0] ht;
    bit accept;
    @(negedge clk);
    mode_dyn  = md;
    arr_vld   = av;
    arr_dst   = IW'(dst);
    conn_port = IW'(cn);
    th = md ? (mtot >> LG) : NQ;   // R8
    for (int k = 0; k < NQ; k++) begin
      el[k] = (mp[k] == cn) && (mc[k] != 0);   // R2
      ht[k] = el[k] && (mc[k] >= th);
    end
    ev = 1'b1;
    if (ht[mlast]) begin
      eg = mlast; tag = "R4 sticky";
    end else if (ht != '0) begin
      eg = rr_scan(ht, mlast); tag = "R5 hot scan";
    end else if (el[mlast]) begin
      eg = mlast; tag = "R6 keep last";
    end else if (el != '0) begin
      eg = rr_scan(el, mlast); tag = "R7 any scan";
    end else begin
      eg = 0; ev = 1'b0; tag = "R10 idle";
    end
    #5;
    // R12: grant sampled within the same slot as conn_port
    chk(grant_vld == ev, {tag, " valid"}, int'(grant_vld), int'(ev));
    if (ev) chk(int'(grant_q) == eg, {tag, " queue"}, int'(grant_q), eg);
    accept = av && ((mtot < CAP) || ev);   // R11
    if (ev) begin
      mc[eg]--;
      mp[eg] = (cn + 1) % NQ;              // R3
      mlast  = eg;
    end
    if (accept) mc[dst]++;                  // R9
    mtot = mtot + int'(accept) - int'(ev);
  endtask

  initial begin : wdog
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] lf;
    int ng;
    n_chk = 0;
    n_bad = 0;

    // R1: idle after reset for every connected port
    do_reset();
    for (int c = 0; c < NQ; c++) slot(1'b0, 1'b0, 0, c);

    // Vector table walk
    do_reset();
    for (int v = 0; v < 24; v++) begin
      slot(VEC[v][5], VEC[v][4], int'(VEC[v][3:2]), int'(VEC[v][1:0]));
    end

    // R8: same backlog, fixed vs dynamic threshold choose different queues
    for (int m = 0; m < 2; m++) begin
      do_reset();
      for (int a = 0; a < 2; a++) slot(m[0], 1'b1, 1, 3);
      for (int a = 0; a < 5; a++) slot(m[0], 1'b1, 3, 3);
      slot(m[0], 1'b0, 0, 0);
      chk(grant_vld && (int'(grant_q) == (m == 1 ? 1 : 3)), "R8 threshold mode",
          int'(grant_q), (m == 1 ? 1 : 3));
    end

    // R3: pointer advance blocks a repeat on the same port
    do_reset();
    slot(1'b0, 1'b1, 2, 3);
    slot(1'b0, 1'b1, 2, 3);
    slot(1'b0, 1'b0, 0, 0);
    chk(grant_vld && grant_q == 2'd2, "R3 first grant", int'(grant_q), 2);
    slot(1'b0, 1'b0, 0, 0);
    chk(!grant_vld, "R3 same port again", int'(grant_vld), 0);
    slot(1'b0, 1'b0, 0, 1);
    chk(grant_vld && grant_q == 2'd2, "R3 next port", int'(grant_q), 2);

    // R9: arrival and grant to one queue in a slot keep its count
    do_reset();
    slot(1'b0, 1'b1, 0, 3);
    slot(1'b0, 1'b1, 0, 0);
    slot(1'b0, 1'b0, 0, 1);
    chk(grant_vld && grant_q == 2'd0, "R9 count held", int'(grant_vld), 1);
    slot(1'b0, 1'b0, 0, 2);
    chk(!grant_vld, "R9 drained then idle", int'(grant_vld), 0);

    // R11: fill with no matching port, one arrival beyond the cap
    do_reset();
    for (int a = 0; a < CAP + 1; a++) slot(1'b0, 1'b1, a % NQ, 3);
    ng = 0;
    for (int s = 0; s < 48; s++) begin
      slot(1'b0, 1'b0, 0, s % NQ);
      if (grant_vld) ng++;
    end
    chk(ng == CAP, "R11 cells drained", ng, CAP);

    // Broad pseudo-random slots
    do_reset();
    lf = 8'hA5;
    for (int s = 0; s < 400; s++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      slot(lf[7], lf[0] | lf[1], int'(lf[3:2]), (lf[6:4] == 3'd0) ? 3 : s % NQ);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule